// File: doc/BRIEF.md
# Synthesizer Serial Control Register Bank

This block is the programming front end of a frequency synthesizer. Software shifts 24-bit control words in over a three-wire port made of a serial clock, a data line and a load strobe. When the load strobe rises, the finished word is written into one of three holding latches. The latch is chosen by the two lowest bits of the word. Two of these latches, the reference divider word and the feedback divider word, are only stored and presented as raw payload to the divider datapaths, which sit outside this block.

The third latch is the function latch. It is decoded into control outputs: counter hold, power-down, phase detector polarity, charge-pump three-state, the fast-lock enable, mode and timeout code, the two charge-pump current codes and the dual-modulus prescaler select. It also selects the source of a multiplexed status pin. An active-high chip-enable input is OR-combined with the software power-down bit without any register on the path, so a low chip-enable stops the device at once. A synchronised copy of the power-down state is also provided for status reporting. The serial pins are oversampled on the core clock through synchronisers. The serial port keeps accepting and latching words during power-down.

Top module: `synth_ctl_regs`

## Requirements
- R1: Serial data is shifted in MSB first, one bit for each rising edge of `sclk_i`. The last 24 bits shifted are transferred to a latch on a rising edge of `le_i`.
- R2: A word whose bits [1:0] are 00 writes its bits [23:2] to `r_word_o`. The other latches do not change.
- R3: A word whose bits [1:0] are 01 writes its bits [23:2] to `n_word_o`. The other latches do not change.
- R4: A word whose bits [1:0] are 10 writes the function latch. Its fields are decoded as follows:
  - bit 2: counter reset
  - bit 3: software power-down
  - bits 6:4: mux select
  - bit 7: `pd_polarity_o`
  - bit 8: charge-pump three-state request
  - bit 9: `fastlock_en_o`
  - bit 10: `fastlock_mode_o`
  - bits 14:11: `timer_code_o`
  - bits 17:15: `cp_cur1_o`
  - bits 20:18: `cp_cur2_o`
  - bits 23:22: `prescaler_o` (00 = 8/9, 01 = 16/17, 10 = 32/33, 11 = 64/65)
  - bit 21: reserved and not decoded
- R5: A word whose bits [1:0] are 11 leaves all three latches and every decoded output unchanged.
- R6: After reset all latches read zero. All decoded outputs are then low and the mux pin is three-stated (`mux_oe_o`=0, `mux_o`=0).
- R7: `pwr_dn_o` is high when the software power-down bit is 1 or when `ce_i` is low. The path from `ce_i` has no clock delay.
- R8: While `pwr_dn_o` is high, `counter_hold_o` and `cp_tristate_o` are both high, and the lock-detect indication on the mux pin reads 0.
- R9: `counter_hold_o` is high while the counter-reset bit is 1 and falls when a word clears that bit (with power-down off).
- R10: The mux select code drives the mux pin as follows. When `mux_oe_o` is 0, `mux_o` is 0.
  - 000: three-state (`mux_oe_o`=0)
  - 001: lock detect
  - 010: `n_div_i`
  - 011: 1
  - 100: `r_div_i`
  - 101: three-state
  - 110: the shift register MSB
  - 111: 0
- R11: Words shifted and loaded while `pwr_dn_o` is high still update the latches.
- R12: `pd_status_o` follows the power-down state after `ce_i` passes through the synchroniser. It is still low immediately after `ce_i` falls and is high a few core clocks later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial shift clock |
| sdata_i | input | 1 | Serial data |
| le_i | input | 1 | Load strobe, transfers on rising edge |
| ce_i | input | 1 | Chip enable, low forces power-down |
| lock_det_i | input | 1 | Digital lock detect from the loop |
| n_div_i | input | 1 | Feedback divider output |
| r_div_i | input | 1 | Reference divider output |
| r_word_o | output | 22 | Reference divider latch payload |
| n_word_o | output | 22 | Feedback divider latch payload |
| counter_hold_o | output | 1 | Hold R, N and timeout counters at load state |
| pwr_dn_o | output | 1 | Combined power-down |
| pd_status_o | output | 1 | Synchronised power-down status |
| cp_tristate_o | output | 1 | Charge-pump output three-state |
| pd_polarity_o | output | 1 | Phase detector polarity |
| fastlock_en_o | output | 1 | Fast-lock enable |
| fastlock_mode_o | output | 1 | Fast-lock mode select |
| timer_code_o | output | 4 | Fast-lock timeout code |
| cp_cur1_o | output | 3 | Charge-pump current setting 1 |
| cp_cur2_o | output | 3 | Charge-pump current setting 2 |
| prescaler_o | output | 2 | Prescaler modulus select |
| mux_o | output | 1 | Multiplexed status value |
| mux_oe_o | output | 1 | Mux pin drive enable |

## Verification
Two events can land in the same core cycle: a function-latch write that clears the software power-down bit, and a falling chip-enable. The bench first sets the software bit. It then shifts in a word that clears the bit and lowers `ce_i` at the negative clock edge where it raises `le_i`, so the write lands while chip-enable is already low. `pwr_dn_o` is sampled on every cycle of the window and must never drop. Once `ce_i` returns high, power-down must fall, which shows that the write was not lost.

// File: rtl/synctl_pkg.sv
`timescale 1ns/1ps
package synctl_pkg;
    localparam int WORD_W = 24;
    localparam int ADDR_W = 2;
    localparam int PAY_W  = WORD_W - ADDR_W;

    typedef enum logic [1:0] {
        TGT_RDIV = 2'b00,
        TGT_NDIV = 2'b01,
        TGT_FUNC = 2'b10,
        TGT_NONE = 2'b11
    } target_e;

    typedef enum logic [2:0] {
        MX_HIZ  = 3'd0,
        MX_LOCK = 3'd1,
        MX_NDIV = 3'd2,
        MX_HIGH = 3'd3,
        MX_RDIV = 3'd4,
        MX_RSVD = 3'd5,
        MX_SDO  = 3'd6,
        MX_LOW  = 3'd7
    } muxsel_e;

    // Function latch payload, word bits 23:2 packed MSB first
    typedef struct packed {
        logic [1:0] psc;       // 23:22
        logic       rsvd;      // 21
        logic [2:0] cur2;      // 20:18
        logic [2:0] cur1;      // 17:15
        logic [3:0] timer;     // 14:11
        logic       fl_mode;   // 10
        logic       fl_en;     // 9
        logic       cp_hiz;    // 8
        logic       pd_pol;    // 7
        muxsel_e    mux;       // 6:4
        logic       sw_pd;     // 3
        logic       cnt_rst;   // 2
    } func_t;
endpackage

// File: rtl/synctl_sport.sv
`timescale 1ns/1ps
// Oversampled three-wire serial port; SYNC_STAGES must be at least 2.
module synctl_sport
    import synctl_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_i,
    input  logic              sdata_i,
    input  logic              le_i,
    output logic [WORD_W-1:0] word_o,
    output logic              load_o
);
    localparam int TOP = SYNC_STAGES - 1;

    typedef struct packed {
        logic [TOP:0]      sclk_s;
        logic [TOP:0]      sdat_s;
        logic [TOP:0]      le_s;
        logic              sclk_prev;
        logic              le_prev;
        logic [WORD_W-1:0] shreg;
        logic              load;
    } sport_t;

    sport_t sp_q, sp_d;
    logic   sclk_rise, le_rise;

    always_comb begin
        sp_d       = sp_q;
        sclk_rise  = sp_q.sclk_s[TOP] & ~sp_q.sclk_prev;
        le_rise    = sp_q.le_s[TOP] & ~sp_q.le_prev;
        sp_d.sclk_s    = {sp_q.sclk_s[TOP-1:0], sclk_i};
        sp_d.sdat_s    = {sp_q.sdat_s[TOP-1:0], sdata_i};
        sp_d.le_s      = {sp_q.le_s[TOP-1:0], le_i};
        sp_d.sclk_prev = sp_q.sclk_s[TOP];
        sp_d.le_prev   = sp_q.le_s[TOP];
        if (sclk_rise) begin
            sp_d.shreg = {sp_q.shreg[WORD_W-2:0], sp_q.sdat_s[TOP]};
        end
        sp_d.load = le_rise;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sp_q <= '0;
        else        sp_q <= sp_d;
    end

    assign word_o = sp_q.shreg;
    assign load_o = sp_q.load;

    // R1: a detected serial clock edge appends the synchronised data bit
    assert_shift_in_R1: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_rise |=> word_o[0] == $past(sp_q.sdat_s[TOP]));
    // R1: no serial clock edge, no shift
    assert_shift_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !sclk_rise |=> $stable(word_o));
    // R1: each load strobe edge gives a single-cycle transfer pulse
    assert_load_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
        load_o |=> !load_o);
endmodule

// File: rtl/synctl_bank.sv
`timescale 1ns/1ps
module synctl_bank
    import synctl_pkg::*;
#(
    parameter logic [PAY_W-1:0] R_RST = '0,
    parameter logic [PAY_W-1:0] N_RST = '0,
    parameter logic [PAY_W-1:0] F_RST = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] word_i,
    input  logic              load_i,
    output logic [PAY_W-1:0]  r_o,
    output logic [PAY_W-1:0]  n_o,
    output logic [PAY_W-1:0]  f_o
);
    typedef struct packed {
        logic [PAY_W-1:0] r;
        logic [PAY_W-1:0] n;
        logic [PAY_W-1:0] f;
    } bank_t;

    bank_t   bk_q, bk_d;
    target_e tgt;
    logic [PAY_W-1:0] payload;

    always_comb begin
        bk_d    = bk_q;
        tgt     = target_e'(word_i[ADDR_W-1:0]);
        payload = word_i[WORD_W-1:ADDR_W];
        if (load_i) begin
            unique case (tgt)
                TGT_RDIV: bk_d.r = payload;
                TGT_NDIV: bk_d.n = payload;
                TGT_FUNC: bk_d.f = payload;
                default:  bk_d   = bk_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bk_q.r <= R_RST;
            bk_q.n <= N_RST;
            bk_q.f <= F_RST;
        end else begin
            bk_q <= bk_d;
        end
    end

    assign r_o = bk_q.r;
    assign n_o = bk_q.n;
    assign f_o = bk_q.f;

    assert_rdiv_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load_i && word_i[1:0] == 2'b00 |=>
            r_o == $past(word_i[WORD_W-1:ADDR_W]) && $stable(n_o) && $stable(f_o));
    assert_ndiv_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        load_i && word_i[1:0] == 2'b01 |=>
            n_o == $past(word_i[WORD_W-1:ADDR_W]) && $stable(r_o) && $stable(f_o));
    assert_func_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        load_i && word_i[1:0] == 2'b10 |=>
            f_o == $past(word_i[WORD_W-1:ADDR_W]) && $stable(r_o) && $stable(n_o));
    assert_no_target_R5: assert property (@(posedge clk) disable iff (!rst_n)
        load_i && word_i[1:0] == 2'b11 |=> $stable(r_o) && $stable(n_o) && $stable(f_o));
endmodule

// File: rtl/synctl_fdec.sv
`timescale 1ns/1ps
// Function latch decode, power-down combine and status multiplexer.
module synctl_fdec
    import synctl_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic  clk,
    input  logic  rst_n,
    input  func_t f_i,
    input  logic  ce_i,
    input  logic  lock_det_i,
    input  logic  n_div_i,
    input  logic  r_div_i,
    input  logic  sdo_i,
    output logic  pwr_dn_o,
    output logic  pd_status_o,
    output logic  counter_hold_o,
    output logic  cp_tristate_o,
    output logic  mux_o,
    output logic  mux_oe_o
);
    localparam int TOP = SYNC_STAGES - 1;

    typedef struct packed {
        logic [TOP:0] ce_s;
        logic         pd_stat;
    } fdec_t;

    localparam fdec_t FDEC_RST = '{ce_s: '1, pd_stat: 1'b0};

    fdec_t st_q, st_d;
    logic  pd_now;
    logic  lock_ok;

    always_comb begin
        st_d         = st_q;
        st_d.ce_s    = {st_q.ce_s[TOP-1:0], ce_i};
        st_d.pd_stat = f_i.sw_pd | ~st_q.ce_s[TOP];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= FDEC_RST;
        else        st_q <= st_d;
    end

    // Chip enable reaches power-down with no register on the way
    always_comb begin
        pd_now         = f_i.sw_pd | ~ce_i;
        lock_ok        = lock_det_i & ~pd_now;
        counter_hold_o = f_i.cnt_rst | pd_now;
        cp_tristate_o  = f_i.cp_hiz | pd_now;
    end

    always_comb begin
        mux_o    = 1'b0;
        mux_oe_o = 1'b1;
        unique case (f_i.mux)
            MX_HIZ:  mux_oe_o = 1'b0;
            MX_LOCK: mux_o    = lock_ok;
            MX_NDIV: mux_o    = n_div_i;
            MX_HIGH: mux_o    = 1'b1;
            MX_RDIV: mux_o    = r_div_i;
            MX_RSVD: mux_oe_o = 1'b0;
            MX_SDO:  mux_o    = sdo_i;
            MX_LOW:  mux_o    = 1'b0;
            default: mux_oe_o = 1'b0;
        endcase
    end

    assign pwr_dn_o    = pd_now;
    assign pd_status_o = st_q.pd_stat;

    // R8: power-down holds counters, floats the pump and hides lock detect
    assert_pd_effects_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_dn_o |-> counter_hold_o && cp_tristate_o &&
                     (f_i.mux != MX_LOCK || !mux_o));
    // R9: counter reset bit always holds the counters
    assert_cnt_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        f_i.cnt_rst |-> counter_hold_o);
    // R10: an undriven pin reads low
    assert_hiz_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !mux_oe_o |-> !mux_o);
    // R12: status only rises from a power-down that was present a cycle earlier
    assert_status_src_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pd_status_o) |-> $past(f_i.sw_pd) || !$past(st_q.ce_s[TOP]));
endmodule

// File: rtl/synth_ctl_regs.sv
`timescale 1ns/1ps
module synth_ctl_regs
    import synctl_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sclk_i,
    input  logic             sdata_i,
    input  logic             le_i,
    input  logic             ce_i,
    input  logic             lock_det_i,
    input  logic             n_div_i,
    input  logic             r_div_i,
    output logic [PAY_W-1:0] r_word_o,
    output logic [PAY_W-1:0] n_word_o,
    output logic             counter_hold_o,
    output logic             pwr_dn_o,
    output logic             pd_status_o,
    output logic             cp_tristate_o,
    output logic             pd_polarity_o,
    output logic             fastlock_en_o,
    output logic             fastlock_mode_o,
    output logic [3:0]       timer_code_o,
    output logic [2:0]       cp_cur1_o,
    output logic [2:0]       cp_cur2_o,
    output logic [1:0]       prescaler_o,
    output logic             mux_o,
    output logic             mux_oe_o
);
    logic [WORD_W-1:0] shift_word;
    logic              load_pulse;
    logic [PAY_W-1:0]  func_raw;
    func_t             func;

    synctl_sport #(.SYNC_STAGES(SYNC_STAGES)) i_sport (
        .clk     (clk),
        .rst_n   (rst_n),
        .sclk_i  (sclk_i),
        .sdata_i (sdata_i),
        .le_i    (le_i),
        .word_o  (shift_word),
        .load_o  (load_pulse)
    );

    synctl_bank i_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .word_i (shift_word),
        .load_i (load_pulse),
        .r_o    (r_word_o),
        .n_o    (n_word_o),
        .f_o    (func_raw)
    );

    assign func = func_t'(func_raw);

    synctl_fdec #(.SYNC_STAGES(SYNC_STAGES)) i_fdec (
        .clk            (clk),
        .rst_n          (rst_n),
        .f_i            (func),
        .ce_i           (ce_i),
        .lock_det_i     (lock_det_i),
        .n_div_i        (n_div_i),
        .r_div_i        (r_div_i),
        .sdo_i          (shift_word[WORD_W-1]),
        .pwr_dn_o       (pwr_dn_o),
        .pd_status_o    (pd_status_o),
        .counter_hold_o (counter_hold_o),
        .cp_tristate_o  (cp_tristate_o),
        .mux_o          (mux_o),
        .mux_oe_o       (mux_oe_o)
    );

    assign pd_polarity_o   = func.pd_pol;
    assign fastlock_en_o   = func.fl_en;
    assign fastlock_mode_o = func.fl_mode;
    assign timer_code_o    = func.timer;
    assign cp_cur1_o       = func.cur1;
    assign cp_cur2_o       = func.cur2;
    assign prescaler_o     = func.psc;

    // R7: a low chip enable is seen as power-down in the same cycle
    assert_ce_pd_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !ce_i |-> pwr_dn_o && cp_tristate_o);
endmodule

// File: tb/test_synth_ctl_regs.sv
`timescale 1ns/1ps
module test_synth_ctl_regs;
    localparam int HALF = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0, sdata = 1'b0, le = 1'b0, ce = 1'b1;
    logic lock_det = 1'b0, n_div = 1'b0, r_div = 1'b0;
    logic [21:0] r_word, n_word;
    logic counter_hold, pwr_dn, pd_status, cp_tristate, pd_polarity;
    logic fastlock_en, fastlock_mode, mux, mux_oe;
    logic [3:0] timer_code;
    logic [2:0] cp_cur1, cp_cur2;
    logic [1:0] prescaler;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    synth_ctl_regs i_synth_ctl_regs (
        .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .sdata_i(sdata), .le_i(le),
        .ce_i(ce), .lock_det_i(lock_det), .n_div_i(n_div), .r_div_i(r_div),
        .r_word_o(r_word), .n_word_o(n_word), .counter_hold_o(counter_hold),
        .pwr_dn_o(pwr_dn), .pd_status_o(pd_status), .cp_tristate_o(cp_tristate),
        .pd_polarity_o(pd_polarity), .fastlock_en_o(fastlock_en),
        .fastlock_mode_o(fastlock_mode), .timer_code_o(timer_code),
        .cp_cur1_o(cp_cur1), .cp_cur2_o(cp_cur2), .prescaler_o(prescaler),
        .mux_o(mux), .mux_oe_o(mux_oe)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [23:0] mk_func(
        input logic [1:0] psc, input logic [2:0] cur2, input logic [2:0] cur1,
        input logic [3:0] tmr, input logic flm, input logic fle, input logic cphiz,
        input logic pol, input logic [2:0] msel, input logic pd, input logic crst);
        return {psc, 1'b0, cur2, cur1, tmr, flm, fle, cphiz, pol, msel, pd, crst, 2'b10};
    endfunction

    task automatic shift_bits(input logic [23:0] w);
        for (int i = 23; i >= 0; i--) begin
            @(negedge clk); sdata = w[i];
            repeat (HALF) @(negedge clk); sclk = 1'b1;
            repeat (HALF) @(negedge clk); sclk = 1'b0;
        end
        repeat (HALF) @(negedge clk);
    endtask

    task automatic strobe();
        le = 1'b1;
        repeat (HALF) @(negedge clk); le = 1'b0;
        repeat (6) @(negedge clk);
        #1;
    endtask

    task automatic send_word(input logic [23:0] w);
        shift_bits(w);
        strobe();
    endtask

    task automatic t_reset();
        chk("R6", "r_word", r_word, 0);
        chk("R6", "n_word", n_word, 0);
        chk("R6", "decoded", {counter_hold, pwr_dn, cp_tristate, pd_polarity,
            fastlock_en, fastlock_mode, timer_code, cp_cur1, cp_cur2, prescaler}, 0);
        chk("R6", "mux pin", {mux_oe, mux}, 0);
        chk("R6", "pd_status", pd_status, 0);
    endtask

    task automatic t_rlatch();
        send_word({22'h15A5A5, 2'b00});
        chk("R2", "r_word", r_word, 22'h15A5A5);
        chk("R2", "n_word untouched", n_word, 0);
        chk("R1", "mux still hiz", mux_oe, 0);
    endtask

    task automatic t_nlatch();
        send_word({22'h0F0F3C, 2'b01});
        chk("R3", "n_word", n_word, 22'h0F0F3C);
        chk("R3", "r_word untouched", r_word, 22'h15A5A5);
    endtask

    task automatic t_func();
        send_word(mk_func(2'b10, 3'b101, 3'b011, 4'b1001, 1'b1, 1'b1, 1'b0, 1'b1,
                          3'b011, 1'b0, 1'b0));
        chk("R4", "prescaler", prescaler, 2'b10);
        chk("R4", "cur2", cp_cur2, 3'b101);
        chk("R4", "cur1", cp_cur1, 3'b011);
        chk("R4", "timer", timer_code, 4'b1001);
        chk("R4", "fl mode/en pol", {fastlock_mode, fastlock_en, pd_polarity}, 3'b111);
        chk("R4", "pump/hold/pd", {cp_tristate, counter_hold, pwr_dn}, 0);
        chk("R4", "mux high", {mux_oe, mux}, 2'b11);
        chk("R4", "r/n untouched", {r_word, n_word}, {22'h15A5A5, 22'h0F0F3C});
    endtask

    task automatic t_addr3();
        send_word(24'hFFFFFF);
        chk("R5", "r_word", r_word, 22'h15A5A5);
        chk("R5", "n_word", n_word, 22'h0F0F3C);
        chk("R5", "func fields", {prescaler, cp_cur2, cp_cur1, timer_code,
            fastlock_mode, fastlock_en, pd_polarity, cp_tristate, counter_hold, pwr_dn},
            {2'b10, 3'b101, 3'b011, 4'b1001, 3'b111, 3'b000});
    endtask

    task automatic t_mux();
        lock_det = 1'b1; n_div = 1'b1; r_div = 1'b0;
        send_word(mk_func(2'b01, 0, 0, 0, 0, 0, 0, 0, 3'b000, 0, 0));
        chk("R10", "sel 000", {mux_oe, mux}, 2'b00);
        send_word(mk_func(2'b01, 0, 0, 0, 0, 0, 0, 0, 3'b001, 0, 0));
        chk("R10", "sel 001 lock", {mux_oe, mux}, 2'b11);
        send_word(mk_func(2'b01, 0, 0, 0, 0, 0, 0, 0, 3'b010, 0, 0));
        chk("R10", "sel 010 ndiv", {mux_oe, mux}, 2'b11);
        n_div = 1'b0; #1;
        chk("R10", "sel 010 ndiv low", {mux_oe, mux}, 2'b10);
        send_word(mk_func(2'b01, 0, 0, 0, 0, 0, 0, 0, 3'b100, 0, 0));
        chk("R10", "sel 100 rdiv low", {mux_oe, mux}, 2'b10);
        r_div = 1'b1; #1;
        chk("R10", "sel 100 rdiv high", {mux_oe, mux}, 2'b11);
        send_word(mk_func(2'b01, 0, 0, 0, 0, 0, 0, 0, 3'b101, 0, 0));
        chk("R10", "sel 101", {mux_oe, mux}, 2'b00);
        send_word(mk_func(2'b11, 0, 0, 0, 0, 0, 0, 0, 3'b110, 0, 0));
        chk("R10", "sel 110 sdo one", {mux_oe, mux}, 2'b11);
        send_word(mk_func(2'b01, 0, 0, 0, 0, 0, 0, 0, 3'b110, 0, 0));
        chk("R10", "sel 110 sdo zero", {mux_oe, mux}, 2'b10);
        send_word(mk_func(2'b01, 0, 0, 0, 0, 0, 0, 0, 3'b111, 0, 0));
        chk("R10", "sel 111", {mux_oe, mux}, 2'b10);
        r_div = 1'b0;
    endtask

    task automatic t_cnt_reset();
        send_word(mk_func(2'b00, 0, 0, 0, 0, 0, 0, 0, 3'b001, 1'b0, 1'b1));
        chk("R9", "hold set", {counter_hold, pwr_dn, cp_tristate}, 3'b100);
        send_word(mk_func(2'b00, 0, 0, 0, 0, 0, 0, 0, 3'b001, 1'b0, 1'b0));
        chk("R9", "hold released", counter_hold, 0);
    endtask

    task automatic t_swpd();
        lock_det = 1'b1;
        send_word(mk_func(2'b00, 0, 0, 0, 0, 0, 0, 0, 3'b001, 1'b1, 1'b0));
        chk("R7", "sw pd", pwr_dn, 1);
        chk("R8", "hold and pump", {counter_hold, cp_tristate}, 2'b11);
        chk("R8", "lock hidden", {mux_oe, mux}, 2'b10);
        send_word(mk_func(2'b00, 0, 0, 0, 0, 0, 0, 0, 3'b001, 1'b0, 1'b0));
        chk("R7", "sw pd cleared", {pwr_dn, mux}, 2'b01);
    endtask

    task automatic t_ce();
        @(negedge clk); ce = 1'b0; #1;
        chk("R7", "ce immediate", pwr_dn, 1);
        chk("R12", "status not yet", pd_status, 0);
        chk("R8", "ce hold/pump/lock", {counter_hold, cp_tristate, mux}, 3'b110);
        repeat (4) @(negedge clk); #1;
        chk("R12", "status after sync", pd_status, 1);
        send_word({22'h2C0FFE, 2'b00});
        chk("R11", "write during pd", r_word, 22'h2C0FFE);
        @(negedge clk); ce = 1'b1; #1;
        chk("R7", "ce released", pwr_dn, 0);
        repeat (4) @(negedge clk); #1;
        chk("R12", "status cleared", pd_status, 0);
    endtask

    task automatic t_overlap();
        logic held;
        send_word(mk_func(2'b00, 0, 0, 0, 0, 0, 0, 0, 3'b000, 1'b1, 1'b0));
        shift_bits(mk_func(2'b00, 0, 0, 0, 0, 0, 0, 0, 3'b000, 1'b0, 1'b0));
        le = 1'b1; ce = 1'b0;
        held = 1'b1;
        for (int i = 0; i < 12; i++) begin
            #1; if (pwr_dn !== 1'b1) held = 1'b0;
            @(negedge clk);
            if (i == HALF - 1) le = 1'b0;
        end
        chk("R7", "pd kept across write and ce fall", held, 1);
        ce = 1'b1; #1;
        chk("R11", "write landed under ce", pwr_dn, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk); #1;
        t_reset();
        t_rlatch();
        t_nlatch();
        t_func();
        t_addr3();
        t_mux();
        t_cnt_reset();
        t_swpd();
        t_ce();
        t_overlap();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule